// File: doc/BRIEF.md
# Clock Fan-Out Serial Control Register Slave

This block is the control-register slave of a clock fan-out device with ten differential output pairs. It watches a two-wire serial bus (SCL and SDA) and samples both lines with a faster system clock. It recognises start and stop conditions and compares the 7-bit device address against a parameter. When the address matches, it accepts a write transaction made of a command byte that gives a register index, then a byte count, then the data bytes.

Each data byte goes into one of three 8-bit control registers. The block acknowledges every byte it accepts by pulling SDA low. The register contents leave the block as one enable bit per output pair and one test-select bit for the clock loop. There is no enable bit for the feedback output, so the bus cannot turn that output off. The slave never drives SDA high: `sda_pull_low` drives an open-drain pad.

Top module: `clkfan_serial_regs`

## Requirements
- R1: After synchronous reset, register 0 holds 0xFF, register 1 holds 0xC0 and register 2 holds 0xFF. `pair_en` therefore reads 10'h3FF, `leak_test_sel` reads 0 and `sda_pull_low` reads 0.
- R2: SCL and SDA pass through two-flop synchronisers. A start is SDA falling while SCL stays high. A stop is SDA rising while SCL stays high. A stop returns the slave to idle with SDA released. A start or stop with no bytes between them changes no register.
- R3: The first byte after a start carries the address in bits 7..1 and the direction in bit 0 (0 = write). It is acknowledged only when bits 7..1 equal `DEV_ADDR` and bit 0 is 0.
- R4: When the address does not match, or the direction bit is 1, the slave gives no acknowledge. It then ignores every following byte, without acknowledging or writing, until the next start.
- R5: After an acknowledged address, the first byte is the starting register index and the second is the byte count. Only the bytes after those two are register data, and the first data byte goes into the register named by the index.
- R6: Register 0 bit (7 − i) enables output pair i, for i = 0..7. `pair_en[i]` is 1 when the pair is enabled.
- R7: Register 1 bit 7 enables pair 8 and bit 6 enables pair 9. Bits 5..0 drive no output.
- R8: `leak_test_sel` is 1 exactly when register 2 bit 0 is 0. Register 2 bits 7..1 drive no output.
- R9: Data bytes fill consecutive registers, starting at the index. Once as many bytes as the count gives have been written, later data bytes change nothing. A count of 0 writes nothing.
- R10: A data byte whose register index is 3 or more changes no register.
- R11: Once the address has been accepted, every byte up to the stop is acknowledged, including data bytes that are ignored. The acknowledge is asserted only while the synchronised SCL is low, after the eighth bit, and it holds through the ninth SCL high phase. It is released after the ninth SCL falling edge.
- R12: A repeated start in the middle of a transaction discards that transaction's progress, and the slave then expects an address byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND level) |
| sda_pull_low | output | 1 | 1 = pull SDA low (acknowledge) |
| pair_en | output | 10 | Per-pair output enable, bit i = pair i |
| leak_test_sel | output | 1 | 1 = loop leakage test selected |

## Verification
The bench works on the parts of the transaction that an implementation is most likely to get wrong. It sends data bytes past the byte count and past register 2. It uses a zero count and an index beyond the register bank. A design that skipped these limits would overwrite registers that should keep their values, and the ports would show it. A mismatched address and a read-direction address must get no acknowledge. A design that compared the wrong bits, or ignored the direction bit, would acknowledge them and then write. Every vector also checks the reversed bit order of register 0 and the two pair bits of register 1. A design that mapped these bits straight through would show mirrored enables. A repeated start just before the data, and a reset taken after writes, check that the slave drops a half-finished transaction and returns to the power-up values.

// File: rtl/clkfan_ctl_pkg.sv
package clkfan_ctl_pkg;

    localparam int NUM_REGS  = 3;
    localparam int REG_W     = 8;
    localparam int NUM_PAIRS = 10;
    localparam int IDX_W     = 8;
    localparam int BIT_CNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_DATA,
        ST_SKIP
    } bus_state_e;

    // synchronised line levels plus one-cycle event pulses
    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } line_ev_t;

    function automatic logic [REG_W-1:0] reg_reset_val(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'hC0;
            default: return 8'hFF;
        endcase
    endfunction

    // register 0 is bit-reversed onto pairs 0..7, register 1 top bits onto 8..9
    function automatic logic [NUM_PAIRS-1:0] map_pairs(input logic [REG_W-1:0] r0,
                                                       input logic [REG_W-1:0] r1);
        logic [NUM_PAIRS-1:0] m;
        for (int i = 0; i < 8; i++) begin
            m[i] = r0[7-i];
        end
        m[8] = r1[7];
        m[9] = r1[6];
        return m;
    endfunction

endpackage

// File: rtl/ser_line_sync.sv
module ser_line_sync
    import clkfan_ctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
    end

endmodule

// File: rtl/ser_byte_fsm.sv
module ser_byte_fsm
    import clkfan_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    output logic             ack_drv,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [REG_W-1:0] wr_data,
    output bus_state_e       state
);

    logic [BIT_CNT_W-1:0] bitcnt;
    logic [REG_W-1:0]     shreg;
    logic [IDX_W-1:0]     idx;
    logic [REG_W-1:0]     remain;
    logic                 active;

    assign active = (state != ST_IDLE) && (state != ST_SKIP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            idx     <= '0;
            remain  <= '0;
            ack_drv <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                state   <= ST_ADDR;
                bitcnt  <= '0;
                ack_drv <= 1'b0;
            end else if (ev.stop) begin
                state   <= ST_IDLE;
                bitcnt  <= '0;
                ack_drv <= 1'b0;
            end else if (active) begin
                if (ev.rise) begin
                    if (bitcnt < BIT_CNT_W'(8)) shreg <= {shreg[REG_W-2:0], ev.sda};
                    if (bitcnt != BIT_CNT_W'(9)) bitcnt <= bitcnt + 1'b1;
                end else if (ev.fall) begin
                    if (bitcnt == BIT_CNT_W'(8)) begin
                        unique case (state)
                            ST_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR && !shreg[0]) begin
                                    ack_drv <= 1'b1;
                                    state   <= ST_CMD;
                                end else begin
                                    state   <= ST_SKIP;
                                    bitcnt  <= '0;
                                end
                            end
                            ST_CMD: begin
                                idx     <= shreg;
                                ack_drv <= 1'b1;
                                state   <= ST_COUNT;
                            end
                            ST_COUNT: begin
                                remain  <= shreg;
                                ack_drv <= 1'b1;
                                state   <= ST_DATA;
                            end
                            ST_DATA: begin
                                ack_drv <= 1'b1;
                                if (remain != '0) begin
                                    remain <= remain - 1'b1;
                                    if (idx < IDX_W'(NUM_REGS)) begin
                                        wr_en   <= 1'b1;
                                        wr_idx  <= idx;
                                        wr_data <= shreg;
                                    end
                                    if (idx != '1) idx <= idx + 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end else if (bitcnt == BIT_CNT_W'(9)) begin
                        ack_drv <= 1'b0;
                        bitcnt  <= '0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
    import clkfan_ctl_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [REG_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][REG_W-1:0]  regs
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= reg_reset_val(g);
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                regs[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/clkfan_serial_regs.sv
module clkfan_serial_regs
    import clkfan_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_pull_low,
    output logic [NUM_PAIRS-1:0] pair_en,
    output logic                 leak_test_sel
);

    line_ev_t                          line_ev;
    bus_state_e                        bus_state;
    logic                              wr_en;
    logic [IDX_W-1:0]                  wr_idx;
    logic [REG_W-1:0]                  wr_data;
    logic [NUM_REGS-1:0][REG_W-1:0]    regs;

    ser_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (line_ev)
    );

    ser_byte_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (line_ev),
        .ack_drv (sda_pull_low),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .state   (bus_state)
    );

    ctl_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs    (regs)
    );

    assign pair_en       = map_pairs(regs[0], regs[1]);
    assign leak_test_sel = ~regs[2][0];

endmodule

// File: rtl/clkfan_serial_regs_chk.sv
module clkfan_serial_regs_chk
    import clkfan_ctl_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input line_ev_t             ev,
    input bus_state_e           state,
    input logic                 ack,
    input logic [NUM_PAIRS-1:0] pair_en,
    input logic                 leak
);

    // R1: reset leaves the power-up values on the outputs
    p_reset_defaults_r1: assert property (@(posedge clk)
        rst |=> (pair_en == 10'h3FF && !leak && !ack));

    // R11: acknowledge only starts while the synchronised clock is low
    p_ack_on_low_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> !ev.scl);

    // R2: a stop releases the line and idles the slave
    p_stop_idles_r2: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !ack));

    // R4: an ignored transaction never acknowledges
    p_skip_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !ack);

    // R12: a start always restarts address reception
    p_start_restarts_r12: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR && !ack));

    // R9: outputs move only during the data phase
    p_out_in_data_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable({pair_en, leak}) |-> $past(state) == ST_DATA);

endmodule

bind clkfan_serial_regs clkfan_serial_regs_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ev      (line_ev),
    .state   (bus_state),
    .ack     (sda_pull_low),
    .pair_en (pair_en),
    .leak    (leak_test_sel)
);

// File: tb/test_clkfan_serial_regs.sv
module test_clkfan_serial_regs;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam logic [6:0] ADDR = 7'h69;
    localparam int NV = 8;

    typedef struct packed {
        logic [6:0]  addr;
        logic [7:0]  cmd;
        logic [7:0]  cnt;
        logic [2:0]  nsend;
        logic [31:0] data;
        logic [9:0]  exp_en;
        logic        exp_leak;
        logic        exp_ack;
    } vec_t;

    // V2 wrong address (R4), V3 bytes past count (R9), V4/V5 past reg 2 (R10), V6 zero count (R9)
    localparam vec_t VEC [NV] = '{
        '{7'h69, 8'h00, 8'h01, 3'd1, 32'h0F000000, 10'h3F0, 1'b0, 1'b1},
        '{7'h69, 8'h01, 8'h02, 3'd2, 32'h40FE0000, 10'h2F0, 1'b1, 1'b1},
        '{7'h55, 8'h00, 8'h01, 3'd1, 32'hFF000000, 10'h2F0, 1'b1, 1'b0},
        '{7'h69, 8'h00, 8'h02, 3'd4, 32'h80800000, 10'h101, 1'b1, 1'b1},
        '{7'h69, 8'h02, 8'h03, 3'd3, 32'h01000000, 10'h101, 1'b0, 1'b1},
        '{7'h69, 8'h05, 8'h01, 3'd1, 32'h00000000, 10'h101, 1'b0, 1'b1},
        '{7'h69, 8'h00, 8'h00, 3'd1, 32'h00000000, 10'h101, 1'b0, 1'b1},
        '{7'h69, 8'h00, 8'h03, 3'd3, 32'hFFC0FE00, 10'h3FF, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull_low;
    logic [9:0] pair_en;
    logic       leak_test_sel;
    logic       sda_line;

    int n_chk = 0;
    int n_fail = 0;

    assign sda_line = sda_m & ~sda_pull_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkfan_serial_regs #(.DEV_ADDR(ADDR)) i_clkfan_serial_regs (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .sda_pull_low  (sda_pull_low),
        .pair_en       (pair_en),
        .leak_test_sel (leak_test_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b0;   tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl = 1'b1;   tick(H);
            scl = 1'b0;   tick(2);
        end
        sda_m = 1'b1; tick(H - 2);
        scl = 1'b1;   tick(H / 2);
        ack = sda_pull_low;
        tick(H / 2);
        scl = 1'b0;   tick(2);
    endtask

    task automatic check_out(input string req, input logic [9:0] en, input logic lk);
        check(req, {6'b0, pair_en}, {6'b0, en});
        check(req, {15'b0, leak_test_sel}, {15'b0, lk});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic a;
        tick(4);
        rst = 1'b0;
        tick(4);
        // R1: power-up values
        check_out("R1 reset", 10'h3FF, 1'b0);
        check("R1 sda released", {15'b0, sda_pull_low}, 16'h0);

        for (int v = 0; v < NV; v++) begin
            bus_start();
            send_byte({VEC[v].addr, 1'b0}, a);
            check("R3 R4 address ack", {15'b0, a}, {15'b0, VEC[v].exp_ack});
            send_byte(VEC[v].cmd, a);
            check("R5 R11 command ack", {15'b0, a}, {15'b0, VEC[v].exp_ack});
            send_byte(VEC[v].cnt, a);
            check("R5 R11 count ack", {15'b0, a}, {15'b0, VEC[v].exp_ack});
            for (int k = 0; k < int'(VEC[v].nsend); k++) begin
                send_byte(VEC[v].data[31 - 8*k -: 8], a);
                check("R11 data ack", {15'b0, a}, {15'b0, VEC[v].exp_ack});
            end
            bus_stop();
            tick(4);
            check("R2 idle after stop", {15'b0, sda_pull_low}, 16'h0);
            check_out("R6 R7 R8 R9 R10 outputs", VEC[v].exp_en, VEC[v].exp_leak);
        end

        // R4: right address with read direction gets no ack and writes nothing
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        check("R4 read dir ack", {15'b0, a}, 16'h0);
        send_byte(8'h00, a);
        check("R4 ignored byte ack", {15'b0, a}, 16'h0);
        send_byte(8'h00, a);
        bus_stop(); tick(4);
        check_out("R4 unchanged", 10'h3FF, 1'b1);

        // R2: start then stop with no bytes
        bus_start(); bus_stop(); tick(4);
        check_out("R2 empty frame", 10'h3FF, 1'b1);

        // R12: repeated start after the count byte, then a full write
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(8'h00, a);
        send_byte(8'h01, a);
        bus_start();
        send_byte(8'h00, a);
        check("R12 byte after restart is an address", {15'b0, a}, 16'h0);
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        check("R12 address after restart", {15'b0, a}, 16'h1);
        send_byte(8'h01, a);
        send_byte(8'h01, a);
        send_byte(8'h00, a);
        bus_stop(); tick(4);
        check_out("R12 R7 write after restart", 10'h0FF, 1'b1);

        // R1: reset again after writes
        rst = 1'b1; tick(3); rst = 1'b0; tick(2);
        check_out("R1 second reset", 10'h3FF, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule